// File: doc/BRIEF.md
# PCI Express Error Collector and Notification Router

This block gathers the error events raised by one PCI Express port and turns them into system notifications. Every cycle it takes a vector of uncorrectable error events and a vector of correctable error events, each bit one error kind, together with the requester identifier of the source. A per-bit detect filter decides which events may be recorded. Recorded events set sticky status bits, and software clears those bits by writing 1. A per-bit report filter decides which newly recorded events produce a message. For uncorrectable events, a per-bit severity setting sorts each message into the fatal class or the non-fatal class.

The three message classes (correctable, non-fatal, fatal) are routed to four notification pulses: system error, configuration interrupt, management interrupt and machine check. Each pulse has its own three-bit class enable. A root command register also carries a per-class interrupt enable. That interrupt leaves as a message-signalled pulse when message signalling is selected, and as a legacy INTx pulse otherwise. For each of the two error groups, the block holds a first-error pointer and its source identifier until the error it points at is cleared.

Top module: `pcie_err_router`

## Requirements
- R1: An uncorrectable event whose bit is set in the uncorrectable detect mask (word 1) never sets its status bit (word 0) and produces no pulse.
- R2: A correctable event whose bit is set in the correctable detect mask (word 5) never sets its status bit (word 4) and produces no pulse.
- R3: An event whose bit is set in its report mask (word 2 uncorrectable, word 6 correctable) still sets its status bit but produces no message class and no pulse.
- R4: A newly recorded and reported uncorrectable event is fatal when its bit in the severity register (word 3) is 1, and non-fatal when it is 0.
- R5: The read-only summary at word 7 has bit 0 set when any correctable status bit is set, and bit 3 set when the unsupported-request status bit (index UR_BIT) is set. Bit 1 (non-fatal) and bit 2 (fatal) cover only the uncorrectable status bits other than UR_BIT, split by severity.
- R6: The enables for system error (word 8), configuration interrupt (word 9) and management interrupt (word 10) are independent, and each uses bit 0 for correctable, bit 1 for non-fatal and bit 2 for fatal.
- R7: Status bits at words 0, 4 and 13 stay set until software writes 1 to them. Writing 0 has no effect, and a new event in the same cycle wins over the clear.
- R8: The machine-check pulse fires for a class enabled in word 11, using the same bit order, independently of the other outputs.
- R9: Word 13 records the classes that produced messages (bit 0 correctable, bit 1 non-fatal, bit 2 fatal). Bits 2:0 of word 12 enable the interrupt per class, and bit 3 of word 12 selects the message-signalled pulse (1) or the INTx pulse (0).
- R10: Words 14 (correctable) and 15 (uncorrectable) hold the first error: bit 31 valid, bits 23:16 the lowest newly recorded bit index, and the low bits the source identifier. They latch only while not valid, and valid drops the cycle after the pointed status bit is cleared.
- R11: Each notification output is a one-cycle pulse in the cycle after the event. An event whose status bit is already set produces no pulse.
- R12: All registers reset to 0, which means nothing is masked and nothing is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unc_evt | input | UNC_W | Single-cycle uncorrectable error events |
| cor_evt | input | COR_W | Single-cycle correctable error events |
| evt_src | input | SRC_W | Requester identifier of the current events |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| serr_pulse | output | 1 | System error notification pulse |
| sci_pulse | output | 1 | Configuration interrupt notification pulse |
| smi_pulse | output | 1 | Management interrupt notification pulse |
| mcerr_pulse | output | 1 | Machine-check pulse |
| msi_pulse | output | 1 | Message-signalled interrupt pulse |
| intx_pulse | output | 1 | Legacy INTx interrupt pulse |

## Verification
The bench builds the block with UNC_W=6, COR_W=4, UR_BIT=3 and SRC_W=8. These narrow widths make it cheap to fill and clear whole status words. They put the unsupported-request bit in the middle of the vector, so the summary has to exclude it from neighbours on both sides. They also give the first-error pointer several distinct non-zero values. A scoreboard expects the exact six-output pulse pattern in the cycle after each event, and expects silence in every other cycle. Repeated, masked and report-suppressed events are therefore caught as stray pulses.

// File: rtl/err_route_pkg.sv
package err_route_pkg;
   localparam int ADDR_W   = 4;
   localparam int DATA_W   = 32;
   localparam int N_CLS    = 3;
   localparam int CLS_COR  = 0;
   localparam int CLS_NF   = 1;
   localparam int CLS_FAT  = 2;
   localparam int N_NOTE   = 4;

   typedef logic [N_CLS-1:0] cls_t;

   localparam logic [ADDR_W-1:0] A_UNC_STS  = 4'd0;
   localparam logic [ADDR_W-1:0] A_UNC_DMSK = 4'd1;
   localparam logic [ADDR_W-1:0] A_UNC_RMSK = 4'd2;
   localparam logic [ADDR_W-1:0] A_UNC_SEV  = 4'd3;
   localparam logic [ADDR_W-1:0] A_COR_STS  = 4'd4;
   localparam logic [ADDR_W-1:0] A_COR_DMSK = 4'd5;
   localparam logic [ADDR_W-1:0] A_COR_RMSK = 4'd6;
   localparam logic [ADDR_W-1:0] A_SUMMARY  = 4'd7;
   localparam logic [ADDR_W-1:0] A_EN_SERR  = 4'd8;
   localparam logic [ADDR_W-1:0] A_EN_SCI   = 4'd9;
   localparam logic [ADDR_W-1:0] A_EN_SMI   = 4'd10;
   localparam logic [ADDR_W-1:0] A_EN_MCE   = 4'd11;
   localparam logic [ADDR_W-1:0] A_ROOT_CMD = 4'd12;
   localparam logic [ADDR_W-1:0] A_ROOT_STS = 4'd13;
   localparam logic [ADDR_W-1:0] A_COR_1ST  = 4'd14;
   localparam logic [ADDR_W-1:0] A_UNC_1ST  = 4'd15;
endpackage

// File: rtl/err_capture.sv
module err_capture #(
   parameter int W     = 8,
   parameter int SRC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     evt,
   input  logic [W-1:0]     dmsk,
   input  logic [W-1:0]     clr,
   input  logic [SRC_W-1:0] src,
   output logic [W-1:0]     new_o,
   output logic [W-1:0]     sts_o,
   output logic             first_vld_o,
   output logic [7:0]       first_ptr_o,
   output logic [SRC_W-1:0] first_src_o
);
   localparam int PW = $clog2(W);

   if (W < 2 || W > 32) begin : g_bad_w
      $error("err_capture: W must be 2..32");
   end

   logic [W-1:0]  rec;
   logic [W-1:0]  sts_q;
   logic [PW-1:0] low_idx;
   logic [PW-1:0] ptr_q;

   assign rec   = evt & ~dmsk;
   assign new_o = rec & ~sts_q;
   assign sts_o = sts_q;

   always_comb begin
      low_idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (new_o[i]) low_idx = PW'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_q       <= '0;
         first_vld_o <= 1'b0;
         ptr_q       <= '0;
         first_src_o <= '0;
      end else begin
         sts_q <= (sts_q & ~clr) | rec;
         if (!first_vld_o) begin
            if (|new_o) begin
               first_vld_o <= 1'b1;
               ptr_q       <= low_idx;
               first_src_o <= src;
            end
         end else if (!sts_q[ptr_q]) begin
            first_vld_o <= 1'b0;
         end
      end
   end

   assign first_ptr_o = 8'(ptr_q);

   assert_masked_not_recorded_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt & dmsk & ~sts_q)) |=> ((sts_q & $past(evt & dmsk & ~sts_q)) == '0));

   assert_sticky_until_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((sts_q & $past(sts_q & ~clr)) == $past(sts_q & ~clr)));

   assert_first_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (first_vld_o && sts_q[ptr_q]) |=> ($stable(ptr_q) && $stable(first_src_o)));
endmodule

// File: rtl/err_notify.sv
module err_notify
   import err_route_pkg::*;
#(
   parameter int N_OUT = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  cls_t                  cls,
   input  cls_t [N_OUT-1:0]      en,
   output logic [N_OUT-1:0]      pulse
);
   if (N_OUT < 1) begin : g_bad_n
      $error("err_notify: N_OUT must be at least 1");
   end

   for (genvar k = 0; k < N_OUT; k++) begin : g_out
      always_ff @(posedge clk) begin
         if (!rst_n) pulse[k] <= 1'b0;
         else        pulse[k] <= |(cls & en[k]);
      end

      assert_pulse_needs_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
         pulse[k] |-> $past(|cls));
   end
endmodule

// File: rtl/pcie_err_router.sv
module pcie_err_router
   import err_route_pkg::*;
#(
   parameter int UNC_W  = 12,
   parameter int COR_W  = 8,
   parameter int UR_BIT = 4,
   parameter int SRC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [UNC_W-1:0]  unc_evt,
   input  logic [COR_W-1:0]  cor_evt,
   input  logic [SRC_W-1:0]  evt_src,
   input  logic              reg_wr,
   input  logic [3:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              serr_pulse,
   output logic              sci_pulse,
   output logic              smi_pulse,
   output logic              mcerr_pulse,
   output logic              msi_pulse,
   output logic              intx_pulse
);
   localparam logic [UNC_W-1:0] UR_M = UNC_W'(1) << UR_BIT;

   if (UR_BIT < 0 || UR_BIT >= UNC_W) begin : g_bad_ur
      $error("pcie_err_router: UR_BIT out of range");
   end
   if (SRC_W < 1 || SRC_W > 16) begin : g_bad_src
      $error("pcie_err_router: SRC_W must be 1..16");
   end

   logic [UNC_W-1:0] unc_dmsk, unc_rmsk, unc_sev, unc_clr, unc_new, unc_sts;
   logic [COR_W-1:0] cor_dmsk, cor_rmsk, cor_clr, cor_new, cor_sts;
   cls_t [N_NOTE-1:0] note_en;
   logic [3:0]       root_cmd;
   cls_t             root_sts, cls;
   logic [N_NOTE-1:0] note_p;
   logic             irq;
   logic             unc_fv, cor_fv;
   logic [7:0]       unc_fp, cor_fp;
   logic [SRC_W-1:0] unc_fs, cor_fs;
   logic [3:0]       summary;
   logic             wr_unc_sts, wr_cor_sts, wr_root_sts;

   assign wr_unc_sts  = reg_wr && (reg_addr == A_UNC_STS);
   assign wr_cor_sts  = reg_wr && (reg_addr == A_COR_STS);
   assign wr_root_sts = reg_wr && (reg_addr == A_ROOT_STS);
   assign unc_clr = wr_unc_sts ? reg_wdata[UNC_W-1:0] : '0;
   assign cor_clr = wr_cor_sts ? reg_wdata[COR_W-1:0] : '0;

   err_capture #(.W(UNC_W), .SRC_W(SRC_W)) u_unc (
      .clk(clk), .rst_n(rst_n), .evt(unc_evt), .dmsk(unc_dmsk), .clr(unc_clr),
      .src(evt_src), .new_o(unc_new), .sts_o(unc_sts), .first_vld_o(unc_fv),
      .first_ptr_o(unc_fp), .first_src_o(unc_fs));

   err_capture #(.W(COR_W), .SRC_W(SRC_W)) u_cor (
      .clk(clk), .rst_n(rst_n), .evt(cor_evt), .dmsk(cor_dmsk), .clr(cor_clr),
      .src(evt_src), .new_o(cor_new), .sts_o(cor_sts), .first_vld_o(cor_fv),
      .first_ptr_o(cor_fp), .first_src_o(cor_fs));

   assign cls[CLS_COR] = |(cor_new & ~cor_rmsk);
   assign cls[CLS_NF]  = |(unc_new & ~unc_rmsk & ~unc_sev);
   assign cls[CLS_FAT] = |(unc_new & ~unc_rmsk & unc_sev);

   err_notify #(.N_OUT(N_NOTE)) u_note (
      .clk(clk), .rst_n(rst_n), .cls(cls), .en(note_en), .pulse(note_p));

   assign serr_pulse  = note_p[0];
   assign sci_pulse   = note_p[1];
   assign smi_pulse   = note_p[2];
   assign mcerr_pulse = note_p[3];

   assign irq = |(cls & root_cmd[2:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         unc_dmsk <= '0;
         unc_rmsk <= '0;
         unc_sev  <= '0;
         cor_dmsk <= '0;
         cor_rmsk <= '0;
         note_en  <= '0;
         root_cmd <= '0;
         root_sts <= '0;
         msi_pulse  <= 1'b0;
         intx_pulse <= 1'b0;
      end else begin
         msi_pulse  <= irq & root_cmd[3];
         intx_pulse <= irq & ~root_cmd[3];
         root_sts   <= (root_sts & ~(wr_root_sts ? reg_wdata[2:0] : 3'b000)) | cls;
         if (reg_wr) begin
            case (reg_addr)
               A_UNC_DMSK: unc_dmsk   <= reg_wdata[UNC_W-1:0];
               A_UNC_RMSK: unc_rmsk   <= reg_wdata[UNC_W-1:0];
               A_UNC_SEV:  unc_sev    <= reg_wdata[UNC_W-1:0];
               A_COR_DMSK: cor_dmsk   <= reg_wdata[COR_W-1:0];
               A_COR_RMSK: cor_rmsk   <= reg_wdata[COR_W-1:0];
               A_EN_SERR:  note_en[0] <= reg_wdata[2:0];
               A_EN_SCI:   note_en[1] <= reg_wdata[2:0];
               A_EN_SMI:   note_en[2] <= reg_wdata[2:0];
               A_EN_MCE:   note_en[3] <= reg_wdata[2:0];
               A_ROOT_CMD: root_cmd   <= reg_wdata[3:0];
               default: ;
            endcase
         end
      end
   end

   assign summary[0] = |cor_sts;
   assign summary[1] = |(unc_sts & ~UR_M & ~unc_sev);
   assign summary[2] = |(unc_sts & ~UR_M & unc_sev);
   assign summary[3] = |(unc_sts & UR_M);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_UNC_STS:  reg_rdata = 32'(unc_sts);
         A_UNC_DMSK: reg_rdata = 32'(unc_dmsk);
         A_UNC_RMSK: reg_rdata = 32'(unc_rmsk);
         A_UNC_SEV:  reg_rdata = 32'(unc_sev);
         A_COR_STS:  reg_rdata = 32'(cor_sts);
         A_COR_DMSK: reg_rdata = 32'(cor_dmsk);
         A_COR_RMSK: reg_rdata = 32'(cor_rmsk);
         A_SUMMARY:  reg_rdata = 32'(summary);
         A_EN_SERR:  reg_rdata = 32'(note_en[0]);
         A_EN_SCI:   reg_rdata = 32'(note_en[1]);
         A_EN_SMI:   reg_rdata = 32'(note_en[2]);
         A_EN_MCE:   reg_rdata = 32'(note_en[3]);
         A_ROOT_CMD: reg_rdata = 32'(root_cmd);
         A_ROOT_STS: reg_rdata = 32'(root_sts);
         A_COR_1ST:  reg_rdata = {cor_fv, 7'd0, cor_fp, 16'(cor_fs)};
         A_UNC_1ST:  reg_rdata = {unc_fv, 7'd0, unc_fp, 16'(unc_fs)};
         default:    reg_rdata = '0;
      endcase
   end

   assert_serr_has_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
      serr_pulse |-> ((|unc_sts) || (|cor_sts)));

   assert_irq_has_root_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (msi_pulse || intx_pulse) |-> (root_sts != 3'b000));

   assert_dmask_no_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((unc_evt & ~unc_dmsk) == '0 && (cor_evt & ~cor_dmsk) == '0) |=> !(|note_p));
endmodule

// File: tb/pcie_err_router_bench.sv
module pcie_err_router_bench;
   localparam int UW = 6;
   localparam int CW = 4;
   localparam int SW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [UW-1:0] unc_evt = '0;
   logic [CW-1:0] cor_evt = '0;
   logic [SW-1:0] evt_src = '0;
   logic reg_wr = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic serr_pulse, sci_pulse, smi_pulse, mcerr_pulse, msi_pulse, intx_pulse;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [5:0] exp_q[$];
   string tag_q[$];

   always #2 clk = ~clk;

   pcie_err_router #(.UNC_W(UW), .COR_W(CW), .UR_BIT(3), .SRC_W(SW)) u_pcie_err_router (
      .clk(clk), .rst_n(rst_n), .unc_evt(unc_evt), .cor_evt(cor_evt), .evt_src(evt_src),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .serr_pulse(serr_pulse), .sci_pulse(sci_pulse), .smi_pulse(smi_pulse),
      .mcerr_pulse(mcerr_pulse), .msi_pulse(msi_pulse), .intx_pulse(intx_pulse));

   // pulse bits: 0 serr, 1 sci, 2 smi, 3 mcerr, 4 msi, 5 intx
   localparam logic [5:0] P_SERR = 6'h01, P_SCI = 6'h02, P_SMI = 6'h04,
                          P_MCE = 6'h08, P_MSI = 6'h10, P_INTX = 6'h20;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic fire(input logic [UW-1:0] u, input logic [CW-1:0] c,
                       input logic [SW-1:0] s, input logic [5:0] exp, input string req);
      @(negedge clk);
      unc_evt = u; cor_evt = c; evt_src = s;
      exp_q.push_back(exp);
      tag_q.push_back(req);
      @(negedge clk);
      unc_evt = '0; cor_evt = '0;
   endtask

   // monitor: compares the pulse pattern one step after each capturing edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n) begin
            logic [5:0] act;
            act = {intx_pulse, msi_pulse, mcerr_pulse, smi_pulse, sci_pulse, serr_pulse};
            if (exp_q.size() > 0) begin
               logic [5:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(t, 32'(act), 32'(e));
            end else if (act != 6'h0) begin
               chk("R11 stray pulse", 32'(act), 32'h0);
            end
         end
      end
   end

   initial begin
      #400000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R12 reset state
      for (int a = 0; a < 16; a++) rd(4'(a), 32'h0, "R12 reset value");

      // R6 / R4 non-fatal to system error
      wr(4'd8, 32'h7);
      fire(6'h01, 4'h0, 8'h11, P_SERR, "R4 non-fatal to serr");
      rd(4'd0, 32'h1, "R7 unc status set");
      rd(4'd15, 32'h8000_0011, "R10 unc first latched");
      rd(4'd13, 32'h2, "R9 root nonfatal bit");

      // R4 fatal, R8 machine check, R6 configuration interrupt fatal only
      wr(4'd3, 32'h2);
      wr(4'd9, 32'h4);
      wr(4'd11, 32'h4);
      fire(6'h02, 4'h0, 8'h22, P_SERR | P_SCI | P_MCE, "R4 R8 fatal routing");
      rd(4'd15, 32'h8000_0011, "R10 first held");
      rd(4'd13, 32'h6, "R9 root fatal bit");

      // R11 repeat of a set bit
      fire(6'h02, 4'h0, 8'h22, 6'h0, "R11 repeat no pulse");

      // R1 detect mask
      wr(4'd1, 32'h4);
      fire(6'h04, 4'h0, 8'h23, 6'h0, "R1 masked unc no pulse");
      rd(4'd0, 32'h3, "R1 masked unc not recorded");

      // R2 correctable detect mask, R6 management interrupt
      wr(4'd5, 32'h1);
      wr(4'd10, 32'h1);
      fire(6'h00, 4'h1, 8'h30, 6'h0, "R2 masked cor no pulse");
      rd(4'd4, 32'h0, "R2 masked cor not recorded");
      fire(6'h00, 4'h2, 8'h33, P_SERR | P_SMI, "R6 correctable routing");
      rd(4'd4, 32'h2, "R2 cor recorded");
      rd(4'd14, 32'h8001_0033, "R10 cor first pointer");

      // R3 report mask
      wr(4'd2, 32'h20);
      fire(6'h20, 4'h0, 8'h40, 6'h0, "R3 report masked no pulse");
      rd(4'd0, 32'h23, "R3 status still recorded");

      // R5 summary: cor set, nonfatal bits 0 and 5, fatal bit 1
      rd(4'd7, 32'h7, "R5 summary mixed");

      // R7 write-1-clear, R10 free
      wr(4'd0, 32'h1);
      rd(4'd0, 32'h22, "R7 w1c clears only written bit");
      rd(4'd15, 32'h0000_0011, "R10 first freed");
      wr(4'd0, 32'h0);
      rd(4'd0, 32'h22, "R7 write zero no effect");
      wr(4'd0, 32'h3F);
      wr(4'd4, 32'hF);
      wr(4'd13, 32'h7);
      rd(4'd13, 32'h0, "R9 root w1c");

      // R5 unsupported request only
      fire(6'h08, 4'h0, 8'h44, P_SERR, "R5 UR non-fatal serr");
      rd(4'd7, 32'h8, "R5 UR summary separate");
      rd(4'd15, 32'h8003_0044, "R10 relatch after free");

      // R9 interrupt delivery
      wr(4'd12, 32'h2);
      fire(6'h01, 4'h0, 8'h50, P_SERR | P_INTX, "R9 intx delivery");
      wr(4'd12, 32'hA);
      fire(6'h10, 4'h0, 8'h51, P_SERR | P_MSI, "R9 msi delivery");
      fire(6'h00, 4'h4, 8'h52, P_SERR | P_SMI, "R9 cor not irq enabled");

      // R8 machine check alone
      wr(4'd8, 32'h0);
      wr(4'd9, 32'h0);
      fire(6'h02, 4'h0, 8'h60, P_MCE, "R8 mcerr alone");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule